// File: doc/BRIEF.md
# Dual-Modulus Prescaled Programmable Divider

This block divides a fast input clock by a programmable modulus N and produces one single-cycle pulse per output period. That pulse is the feedback edge for a phase-frequency detector, and it also advances the sigma-delta modulator that drives the divider. The modulus is the sum of two inputs. The first is an integer ratio with a nominal range of 20 to 31. The second is a signed 4-bit offset from the modulator. Because the offset changes from one period to the next, the average ratio can be set in tenth-of-a-unit steps.

Inside the block, a prescaler divides by 3 or by 4, and a modulus controller counts prescaler cycles. Each period runs ceil(N/4) prescaler cycles. The first 4*ceil(N/4) - N of those cycles divide by 3 and the remaining cycles divide by 4.

The modulus is latched once per period, at the edge that ends the previous period. If the requested value falls outside the range that the scheme supports, it is clamped, and a flag reports the clamp for as long as that period runs.

Top module: `mmd_divider`

## Requirements
- R1: `div_pulse` is high for exactly one input clock per output period. In steady state, consecutive pulses are exactly N input clocks apart.
- R2: The requested modulus is `ratio_int` plus `sd_ofs`. `ratio_int` is unsigned. `sd_ofs` is two's complement with a range of -8 to +7 (4'h8 = -8, 4'hF = -1).
- R3: The modulus is sampled only at the edge that ends a period. Input changes made earlier in a period have no effect on the length of that period.
- R4: When `psc_mode` is high, the prescaler divides by 3. When it is low, the prescaler divides by 4. `psc_mode` changes only at a prescaler cycle boundary.
- R5: A period of modulus N contains P = ceil(N/4) prescaler cycles. `psc_mode` is high in the first S = 4P - N of them, which gives 3*S input clocks with the mode high. The last prescaler cycle of every period divides by 4.
- R6: The requested modulus is clamped to the range [RATIO_MIN-4, RATIO_MAX+4], which is [16, 35] by default. `sat_flag` is high for a period whose request was clamped and low otherwise. The flag changes only at a period end.
- R7: Reset is synchronous and active-high. During reset, `div_pulse` stays low, and the modulus and flag load from the present inputs. The first pulse is observed N clocks after reset is released.
- R8: When the offset changes from period to period, the total length of a run of periods equals the sum of the requested, clamped moduli. This holds in particular for a fractional average such as 24.3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_int | input | 5 | Integer division ratio (unsigned) |
| sd_ofs | input | 4 | Signed per-period offset from the modulator |
| div_pulse | output | 1 | One-clock pulse at each output period boundary |
| psc_mode | output | 1 | Prescaler mode line: 1 = divide by 3, 0 = divide by 4 |
| sat_flag | output | 1 | High when the current period's modulus was clamped |

## Verification
The bench applies every integer ratio with zero offset, together with offsets that reach both clamp limits exactly and offsets that cross them. A design that mis-splits the prescaler cycles produces a period that is off by one to three clocks, or a wrong count of divide-by-3 clocks. A design that clamps at the wrong point lets the period run to 38 or 12, or raises the flag on a legal request.

A pulse of offset changes in the middle of a period exposes a controller that samples its inputs continuously instead of once per period, because the current period would then be stretched or shortened. Offset sequences with a mean of 24.3 and with mixed signs detect a controller that drops or repeats a modulus at the reload. Such an error shows up as a total length that differs from the sum of the requests.

// File: rtl/mmd_pkg.sv
`timescale 1ns/1ps
package mmd_pkg;

    localparam int RATIO_W = 5;
    localparam int OFS_W   = 4;
    localparam int MOD_W   = 6;
    localparam int CYC_W   = MOD_W - 2;
    localparam int SEL_W   = 2;

    typedef logic [MOD_W-1:0] modulus_t;

    // One output period expressed in prescaler cycles.
    typedef struct packed {
        logic [CYC_W-1:0] cycles;     // P = ceil(N/4)
        logic [SEL_W-1:0] short_cnt;  // S = 4P - N, cycles in divide-by-3
    } split_t;

    typedef struct packed {
        modulus_t modulus;
        logic     clipped;
    } mod_req_t;

    function automatic split_t split_modulus(input modulus_t n);
        split_t   r;
        modulus_t up;
        modulus_t neg;
        up          = n + modulus_t'(3);
        neg         = modulus_t'(0) - n;
        r.cycles    = up[MOD_W-1:2];
        r.short_cnt = neg[SEL_W-1:0];
        return r;
    endfunction

    function automatic mod_req_t clamp_request(
        input logic        [RATIO_W-1:0] ratio,
        input logic signed [OFS_W-1:0]   ofs,
        input int                        lo,
        input int                        hi
    );
        mod_req_t r;
        int       req;
        req = int'(ratio) + int'(ofs);
        if (req < lo) begin
            r.modulus = modulus_t'(lo);
            r.clipped = 1'b1;
        end else if (req > hi) begin
            r.modulus = modulus_t'(hi);
            r.clipped = 1'b1;
        end else begin
            r.modulus = modulus_t'(req);
            r.clipped = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/mmd_prescaler34.sv
`timescale 1ns/1ps
module mmd_prescaler34 (
    input  logic clk,
    input  logic rst,
    input  logic div3_i,
    output logic tick_o
);
    logic [1:0] phase_q;

    // Last phase of a prescaler cycle: 2 in divide-by-3, 3 in divide-by-4.
    assign tick_o = (phase_q == (div3_i ? 2'd2 : 2'd3));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 2'd0;
        end else if (tick_o) begin
            phase_q <= 2'd0;
        end else begin
            phase_q <= phase_q + 2'd1;
        end
    end
endmodule

// File: rtl/mmd_mod_ctrl.sv
`timescale 1ns/1ps
module mmd_mod_ctrl
    import mmd_pkg::*;
#(
    parameter int MOD_MIN = 16,
    parameter int MOD_MAX = 35
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic        [RATIO_W-1:0] ratio_i,
    input  logic signed [OFS_W-1:0]   ofs_i,
    input  logic                      pre_tick_i,
    output logic                      mode_o,
    output logic                      period_end_o,
    output logic                      clip_o
);
    mod_req_t         req;
    split_t           nxt;
    split_t           act_q;
    logic [CYC_W-1:0] idx_q;
    logic             clip_q;
    logic             last_cyc;

    always_comb begin
        req = clamp_request(ratio_i, ofs_i, MOD_MIN, MOD_MAX);
        nxt = split_modulus(req.modulus);
    end

    assign last_cyc     = (idx_q == act_q.cycles - CYC_W'(1));
    assign period_end_o = pre_tick_i && last_cyc;
    assign mode_o       = (idx_q < CYC_W'(act_q.short_cnt));
    assign clip_o       = clip_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= nxt;
            clip_q <= req.clipped;
            idx_q  <= '0;
        end else if (pre_tick_i) begin
            if (last_cyc) begin
                act_q  <= nxt;
                clip_q <= req.clipped;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + CYC_W'(1);
            end
        end
    end
endmodule

// File: rtl/mmd_divider.sv
`timescale 1ns/1ps
module mmd_divider
    import mmd_pkg::*;
#(
    parameter int RATIO_MIN = 20,
    parameter int RATIO_MAX = 31,
    parameter int SD_MARGIN = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic        [RATIO_W-1:0] ratio_int,
    input  logic signed [OFS_W-1:0]   sd_ofs,
    output logic                      div_pulse,
    output logic                      psc_mode,
    output logic                      sat_flag
);
    localparam int MOD_MIN = RATIO_MIN - SD_MARGIN;
    localparam int MOD_MAX = RATIO_MAX + SD_MARGIN;

    logic ps_tick;
    logic period_end;
    logic pulse_q;

    mmd_prescaler34 i_psc (
        .clk    (clk),
        .rst    (rst),
        .div3_i (psc_mode),
        .tick_o (ps_tick)
    );

    mmd_mod_ctrl #(
        .MOD_MIN (MOD_MIN),
        .MOD_MAX (MOD_MAX)
    ) i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .ratio_i      (ratio_int),
        .ofs_i        (sd_ofs),
        .pre_tick_i   (ps_tick),
        .mode_o       (psc_mode),
        .period_end_o (period_end),
        .clip_o       (sat_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= period_end;
        end
    end

    assign div_pulse = pulse_q;
endmodule

// File: rtl/mmd_divider_chk.sv
`timescale 1ns/1ps
module mmd_divider_chk (
    input logic clk,
    input logic rst,
    input logic div_pulse,
    input logic psc_mode,
    input logic sat_flag,
    input logic ps_tick
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse); // R1

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ps_tick)) |-> $stable(psc_mode)); // R4

    AST_END_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(div_pulse) |-> $past(ps_tick)); // R5

    AST_LAST_DIV4: assert property (@(posedge clk) disable iff (rst)
        $rose(div_pulse) |-> !$past(psc_mode)); // R5

    AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(sat_flag)) |-> div_pulse); // R6
endmodule

bind mmd_divider mmd_divider_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .div_pulse (div_pulse),
    .psc_mode  (psc_mode),
    .sat_flag  (sat_flag),
    .ps_tick   (ps_tick)
);

// File: tb/test_mmd_divider.sv
`timescale 1ns/1ps
module test_mmd_divider;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic        [4:0] ratio_int = 5'd24;
    logic signed [3:0] sd_ofs = 4'sd0;
    logic              div_pulse;
    logic              psc_mode;
    logic              sat_flag;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_pulse_cyc = 0;
    int last_interval = 0;
    int mode_acc = 0;
    int mode_last = 0;
    int seq_o [0:39];

    always #4 clk = ~clk;

    mmd_divider i_mmd_divider (
        .clk       (clk),
        .rst       (rst),
        .ratio_int (ratio_int),
        .sd_ofs    (sd_ofs),
        .div_pulse (div_pulse),
        .psc_mode  (psc_mode),
        .sat_flag  (sat_flag)
    );

    // {ratio[4:0], offset[3:0] two's complement, expected N[5:0], expected flag}
    localparam logic [15:0] VEC [0:17] = '{
        {5'd20, 4'h0, 6'd20, 1'b0}, {5'd21, 4'h0, 6'd21, 1'b0},
        {5'd22, 4'h0, 6'd22, 1'b0}, {5'd23, 4'h0, 6'd23, 1'b0},
        {5'd24, 4'h0, 6'd24, 1'b0}, {5'd25, 4'h0, 6'd25, 1'b0},
        {5'd26, 4'h0, 6'd26, 1'b0}, {5'd27, 4'h0, 6'd27, 1'b0},
        {5'd28, 4'h0, 6'd28, 1'b0}, {5'd29, 4'h0, 6'd29, 1'b0},
        {5'd30, 4'h0, 6'd30, 1'b0}, {5'd31, 4'h0, 6'd31, 1'b0},
        {5'd20, 4'hC, 6'd16, 1'b0}, {5'd31, 4'h4, 6'd35, 1'b0},
        {5'd20, 4'h8, 6'd16, 1'b1}, {5'd31, 4'h7, 6'd35, 1'b1},
        {5'd25, 4'hD, 6'd22, 1'b0}, {5'd3,  4'h0, 6'd16, 1'b1}
    };

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (div_pulse) begin
            last_interval  = cyc - last_pulse_cyc;
            last_pulse_cyc = cyc;
            mode_last      = mode_acc;
            mode_acc       = psc_mode ? 1 : 0;
        end else begin
            mode_acc = mode_acc + (psc_mode ? 1 : 0);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse();
        @(negedge clk);
        while (!div_pulse) @(negedge clk);
        #1;
    endtask

    function automatic int clampn(input int r, input int o);
        int v;
        v = r + o;
        if (v < 16) v = 16;
        if (v > 35) v = 35;
        return v;
    endfunction

    task automatic run_seq(input int r, input int k, input string req);
        int meas;
        int expn;
        meas = 0;
        expn = 0;
        ratio_int = 5'(r);
        for (int j = 0; j < k + 2; j++) begin
            wait_pulse();
            if (j >= 2) begin
                chk(req, last_interval, clampn(r, seq_o[j-2]));
                meas += last_interval;
                expn += clampn(r, seq_o[j-2]);
            end
            if (j < k) sd_ofs = 4'(seq_o[j]);
        end
        chk(req, meas, expn);
        sd_ofs = 4'sd0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rel;
        int acc;
        int sum;
        // R7: reset state and first period
        repeat (3) begin
            @(negedge clk); #1;
            chk("R7 pulse low in reset", int'(div_pulse), 0);
        end
        @(negedge clk); #1;
        rst = 1'b0;
        rel = cyc;
        wait_pulse();
        chk("R7 first period after reset", last_pulse_cyc - rel, 24);

        // R1 R2 R5 R6: vector table
        for (int i = 0; i < 18; i++) begin
            int n;
            int p;
            ratio_int = VEC[i][15:11];
            sd_ofs    = VEC[i][10:7];
            n = int'(VEC[i][6:1]);
            p = (n + 3) / 4;
            repeat (3) wait_pulse();
            chk("R1 R2 period", last_interval, n);
            chk("R6 clamp flag", int'(sat_flag), int'(VEC[i][0]));
            chk("R4 R5 divide-by-3 clocks", mode_last, 3 * (4 * p - n));
        end

        // R3: changes in mid-period do not alter the running period
        ratio_int = 5'd27;
        sd_ofs = 4'sd0;
        repeat (3) wait_pulse();
        #48;
        sd_ofs = 4'sd7;
        #48;
        sd_ofs = 4'sd0;
        wait_pulse();
        chk("R3 glitch ignored", last_interval, 27);
        #48;
        sd_ofs = 4'sd5;
        wait_pulse();
        chk("R3 running period kept", last_interval, 27);
        wait_pulse();
        chk("R3 next period uses new offset", last_interval, 32);
        sd_ofs = 4'sd0;

        // R8: first-order fractional sequence, mean 24.3
        acc = 0;
        for (int j = 0; j < 20; j++) begin
            acc += 3;
            if (acc >= 10) begin
                acc -= 10;
                seq_o[j] = 1;
            end else begin
                seq_o[j] = 0;
            end
        end
        run_seq(24, 20, "R8 fractional 24.3");
        sum = 0;
        for (int j = 0; j < 20; j++) sum += 24 + seq_o[j];
        chk("R8 fractional total", sum, 486);

        // R8: mixed-sign offsets, including clamped ones
        for (int j = 0; j < 32; j++) seq_o[j] = ((j * 3) % 16) - 8;
        run_seq(22, 32, "R8 mixed offsets");

        // R7: reset in the middle of operation
        ratio_int = 5'd3;
        sd_ofs = 4'sd0;
        @(negedge clk); #1;
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk); #1;
            chk("R7 pulse low in reset", int'(div_pulse), 0);
        end
        chk("R7 flag loaded in reset", int'(sat_flag), 1);
        ratio_int = 5'd30;
        @(negedge clk); #1;
        rst = 1'b0;
        rel = cyc;
        wait_pulse();
        chk("R7 first period after reset", last_pulse_cyc - rel, 30);
        chk("R7 flag clear", int'(sat_flag), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule